// File: doc/BRIEF.md
# Two-Wire Debug Target Interface

This block is the target side of a two-wire programming and debug link. The host drives one clock pin (shared with the device reset) and one bidirectional data line. Each low strobe on the clock pin carries one bit of a frame. The target samples host-driven bits when the strobe ends, and it puts its own bits on the line when a strobe begins. A low pulse that lasts too long is not a strobe: it is a device reset, which aborts any frame in progress and returns the address register to zero.

Every frame opens with a start strobe and a two-bit instruction. Four frame kinds are decoded: address write, address read, data write and data read. Data frames carry a two-bit byte count and a wait field, and all traffic passes through one eight-bit shift register, least significant bit first. The address register selects one of three data registers:
- a read-only device identifier;
- a read-only revision identifier;
- a programming data register shared with a local programming engine.

An address read does not return the address. It returns a status byte that the host polls as a handshake. The programming engine side sees a write strobe, an acknowledge input, and a result-valid input.

Top module: `dbg_target`

## Requirements
- R1: The address register is 0x00 after system reset and after a pin reset, so a data read issued with no preceding address write returns the device identifier.
- R2: Address 0x00 reads DEV_ID and address 0x01 reads REV_ID. Any address other than these and PROG_ADDR reads 0x00. Data writes to 0x00 and 0x01 change nothing and raise no engine write strobe.
- R3: An address read returns a status byte laid out as follows: bit 7 is engBusy, bit 6 is engError, bits 5..2 are zero, bit 1 is input-busy, and bit 0 is output-ready.
- R4: A data write to PROG_ADDR pulses pdWrStb for exactly one clock and presents the written byte on pdWrData. It also sets input-busy, which stays set until pdWrAck is seen.
- R5: A pdRdValid pulse latches pdRdData and sets output-ready. A data read of PROG_ADDR returns the latched byte and clears output-ready.
- R6: During the wait field the target answers each poll strobe with 0 or 1. After a write to PROG_ADDR it answers 0 while input-busy is set. For a read of PROG_ADDR it answers 0 while output-ready is clear. For every other address it answers 1 on the first poll. Only an answer of 1 ends the wait field.
- R7: Instruction codes are data read = 0, data write = 1, address read = 2 and address write = 3. Instruction, count and data bits are all sent bit 0 first. A count field of n moves n+1 bytes. A multi-byte read repeats the selected register. A multi-byte write commits only its last byte.
- R8: lineOe is low during every host-owned field. It rises at the first target-owned strobe of a frame and falls on the rising edge of the stop strobe.
- R9: A clock-pin low lasting at least LOW_RESET_CLKS system clocks gives one tgtReset pulse, aborts the frame, releases the line and zeroes the address. Shorter lows are protocol strobes and never cause a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low system reset |
| ckPin | input | 1 | Shared clock/reset pin, idle high, asynchronous |
| lineIn | input | 1 | Level currently seen on the data line |
| lineOut | output | 1 | Value the target drives on the data line |
| lineOe | output | 1 | Target drive enable for the data line |
| engBusy | input | 1 | Programming engine busy flag (status bit 7) |
| engError | input | 1 | Programming engine error flag (status bit 6) |
| pdWrStb | output | 1 | One-clock strobe when the host writes the programming data register |
| pdWrData | output | 8 | Byte written by the host |
| pdWrAck | input | 1 | Engine has taken the written byte |
| pdRdValid | input | 1 | Engine places a result byte |
| pdRdData | input | 8 | Result byte from the engine |
| tgtReset | output | 1 | One-clock pulse on a detected pin reset |

## Verification
The bench writes every byte value to the programming register. For each write the engine acknowledge is delayed by zero, one or two polls, and the bench checks that the wait field returns exactly that many zeros. A target that ended the wait early would let the host race ahead of the engine, and one that never answered 1 would hang the frame. The bench also stalls a write so that input-busy stays set, then clears it with a pin reset. This shows the status bit outliving the aborted frame, the address returning to the device identifier, and the line being released; a classifier that treated long lows as strobes would leave the target stuck in the middle of a frame. The remaining sweeps read every result value through the output-ready handshake, run multi-byte counts so that a wrong byte count or a repeated commit shows up as an extra strobe, and attempt writes to the read-only identifiers.

// File: rtl/dbgt_pkg.sv
package dbgt_pkg;
  localparam int DW = 8;
  localparam int BW = $clog2(DW);

  localparam logic [1:0] INS_DREAD  = 2'd0;
  localparam logic [1:0] INS_DWRITE = 2'd1;
  localparam logic [1:0] INS_AREAD  = 2'd2;
  localparam logic [1:0] INS_AWRITE = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_INS, ST_ADDRW, ST_ADDRR, ST_LEN,
    ST_DATAW, ST_WAITW, ST_WAITR, ST_DATAR, ST_STOP
  } frameState_t;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadStatus;
    logic loadData;
    logic commitAddr;
    logic commitWrite;
    logic driveShift;
    logic driveWaitW;
    logic driveWaitR;
    logic abort;
  } ctlStrobe_t;
endpackage

// File: rtl/dbgt_pin_cond.sv
module dbgt_pin_cond #(
  parameter int LOW_RESET_CLKS = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ckPin,
  input  logic lineIn,
  output logic ckFall,
  output logic ckRise,
  output logic lineBit,
  output logic resetPulse
);
  localparam int CW = $clog2(LOW_RESET_CLKS + 1);

  logic [SYNC_STAGES-1:0] ckSync;
  logic [SYNC_STAGES-1:0] lineSync;
  logic ckS;
  logic ckPrev;
  logic longLow;
  logic [CW-1:0] lowCnt;

  assign ckS     = ckSync[SYNC_STAGES-1];
  assign lineBit = lineSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckSync   <= '1;
      lineSync <= '1;
      ckPrev   <= 1'b1;
    end else begin
      ckSync   <= {ckSync[SYNC_STAGES-2:0], ckPin};
      lineSync <= {lineSync[SYNC_STAGES-2:0], lineIn};
      ckPrev   <= ckS;
    end
  end

  // low-width classifier
  assign resetPulse = !ckS && (lowCnt == CW'(LOW_RESET_CLKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      longLow <= 1'b0;
    end else begin
      if (ckS) lowCnt <= '0;
      else if (lowCnt != CW'(LOW_RESET_CLKS)) lowCnt <= lowCnt + 1'b1;
      if (resetPulse) longLow <= 1'b1;
      else if (ckS) longLow <= 1'b0;
    end
  end

  assign ckFall = ckPrev && !ckS;
  assign ckRise = !ckPrev && ckS && !longLow;

  assert_reset_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    resetPulse |=> !resetPulse);
  assert_rise_short_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    ckRise |-> (lowCnt < CW'(LOW_RESET_CLKS)));
endmodule

// File: rtl/dbgt_ctrl.sv
module dbgt_ctrl
  import dbgt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ckFall,
  input  logic       ckRise,
  input  logic       lineBit,
  input  logic       driveBitNow,
  input  logic       resetPulse,
  output ctlStrobe_t strb,
  output logic       dataOe
);
  frameState_t state;
  logic [BW-1:0] bitCnt;
  logic [1:0] bytesLeft;
  logic [1:0] insReg;
  logic [1:0] lenReg;
  logic [1:0] insNow;
  logic [1:0] lenNow;
  logic lastBit;
  logic targetOwned;

  assign insNow  = {lineBit, insReg[1]};
  assign lenNow  = {lineBit, lenReg[1]};
  assign lastBit = (bitCnt == BW'(DW - 1));
  assign targetOwned = (state == ST_ADDRR) || (state == ST_DATAR) ||
                       (state == ST_WAITW) || (state == ST_WAITR);

  always_comb begin
    strb = '0;
    strb.abort = resetPulse;
    if (ckFall && !resetPulse) begin
      case (state)
        ST_ADDRR, ST_DATAR: strb.driveShift = 1'b1;
        ST_WAITW:           strb.driveWaitW = 1'b1;
        ST_WAITR:           strb.driveWaitR = 1'b1;
        default: ;
      endcase
    end
    if (ckRise) begin
      case (state)
        ST_INS:   if (bitCnt[0] && insNow == INS_AREAD) strb.loadStatus = 1'b1;
        ST_ADDRW: begin strb.shiftIn = 1'b1; strb.commitAddr = lastBit; end
        ST_ADDRR: strb.shiftOut = 1'b1;
        ST_DATAW: begin
          strb.shiftIn = 1'b1;
          strb.commitWrite = lastBit && (bytesLeft == 2'd0);
        end
        ST_WAITR: strb.loadData = driveBitNow;
        ST_DATAR: begin
          strb.shiftOut = 1'b1;
          strb.loadData = lastBit && (bytesLeft != 2'd0);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      bytesLeft <= '0;
      insReg    <= '0;
      lenReg    <= '0;
      dataOe    <= 1'b0;
    end else if (resetPulse) begin
      state  <= ST_IDLE;
      dataOe <= 1'b0;
    end else if (ckFall) begin
      if (targetOwned) dataOe <= 1'b1;
    end else if (ckRise) begin
      case (state)
        ST_IDLE: begin state <= ST_INS; bitCnt <= '0; end
        ST_INS: begin
          insReg <= insNow;
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt[0]) begin
            bitCnt <= '0;
            if (insNow == INS_AWRITE) state <= ST_ADDRW;
            else if (insNow == INS_AREAD) state <= ST_ADDRR;
            else state <= ST_LEN;
          end
        end
        ST_LEN: begin
          lenReg <= lenNow;
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt[0]) begin
            bitCnt    <= '0;
            bytesLeft <= lenNow;
            state     <= (insReg == INS_DWRITE) ? ST_DATAW : ST_WAITR;
          end
        end
        ST_ADDRW, ST_ADDRR: begin
          bitCnt <= bitCnt + 1'b1;
          if (lastBit) state <= ST_STOP;
        end
        ST_DATAW, ST_DATAR: begin
          bitCnt <= bitCnt + 1'b1;
          if (lastBit) begin
            if (bytesLeft == 2'd0) state <= (state == ST_DATAW) ? ST_WAITW : ST_STOP;
            else bytesLeft <= bytesLeft - 1'b1;
          end
        end
        ST_WAITW: if (driveBitNow) state <= ST_STOP;
        ST_WAITR: if (driveBitNow) begin state <= ST_DATAR; bitCnt <= '0; end
        ST_STOP: begin state <= ST_IDLE; dataOe <= 1'b0; end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_oe_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataOe) |-> $past(state == ST_STOP || strb.abort));
  assert_oe_owned_R8: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (targetOwned || state == ST_STOP));
endmodule

// File: rtl/dbgt_dpath.sv
module dbgt_dpath
  import dbgt_pkg::*;
#(
  parameter logic [DW-1:0] DEV_ID    = 8'hC3,
  parameter logic [DW-1:0] REV_ID    = 8'h05,
  parameter logic [DW-1:0] PROG_ADDR = 8'h2A
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strb,
  input  logic          lineBit,
  input  logic          engBusy,
  input  logic          engError,
  input  logic          pdWrAck,
  input  logic          pdRdValid,
  input  logic [DW-1:0] pdRdData,
  output logic          lineOut,
  output logic          pdWrStb,
  output logic [DW-1:0] pdWrData
);
  logic [DW-1:0] shReg;
  logic [DW-1:0] addrReg;
  logic [DW-1:0] rdLatch;
  logic [DW-1:0] shiftedIn;
  logic [DW-1:0] readValue;
  logic [DW-1:0] statusByte;
  logic inBusy;
  logic outReady;
  logic isProg;

  assign shiftedIn  = {lineBit, shReg[DW-1:1]};
  assign isProg     = (addrReg == PROG_ADDR);
  assign statusByte = {engBusy, engError, 4'b0000, inBusy, outReady};

  always_comb begin
    if (addrReg == 8'h00) readValue = DEV_ID;
    else if (addrReg == 8'h01) readValue = REV_ID;
    else if (isProg) readValue = rdLatch;
    else readValue = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      addrReg  <= '0;
      rdLatch  <= '0;
      pdWrData <= '0;
      pdWrStb  <= 1'b0;
      inBusy   <= 1'b0;
      outReady <= 1'b0;
      lineOut  <= 1'b1;
    end else begin
      if (strb.loadStatus) shReg <= statusByte;
      else if (strb.loadData) shReg <= readValue;
      else if (strb.shiftIn) shReg <= shiftedIn;
      else if (strb.shiftOut) shReg <= {1'b0, shReg[DW-1:1]};

      if (strb.abort) addrReg <= '0;
      else if (strb.commitAddr) addrReg <= shiftedIn;

      pdWrStb <= strb.commitWrite && isProg;
      if (strb.commitWrite && isProg) pdWrData <= shiftedIn;

      if (strb.commitWrite && isProg) inBusy <= 1'b1;
      else if (pdWrAck) inBusy <= 1'b0;

      if (pdRdValid) begin
        outReady <= 1'b1;
        rdLatch  <= pdRdData;
      end else if (strb.loadData && isProg) begin
        outReady <= 1'b0;
      end

      if (strb.driveShift) lineOut <= shReg[0];
      else if (strb.driveWaitW) lineOut <= isProg ? !inBusy : 1'b1;
      else if (strb.driveWaitR) lineOut <= isProg ? outReady : 1'b1;
    end
  end

  assert_wrstb_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    pdWrStb |=> !pdWrStb);
  assert_inbusy_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inBusy && !pdWrAck) |=> inBusy);
  assert_outready_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadData && isProg && !pdRdValid) |=> !outReady);
  assert_addr_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> (addrReg == '0));
  assert_status_pad_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadStatus |=> (shReg[5:2] == 4'b0000));
endmodule

// File: rtl/dbg_target.sv
module dbg_target
  import dbgt_pkg::*;
#(
  parameter logic [7:0] DEV_ID         = 8'hC3,
  parameter logic [7:0] REV_ID         = 8'h05,
  parameter logic [7:0] PROG_ADDR      = 8'h2A,
  parameter int         LOW_RESET_CLKS = 16,
  parameter int         SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ckPin,
  input  logic       lineIn,
  output logic       lineOut,
  output logic       lineOe,
  input  logic       engBusy,
  input  logic       engError,
  output logic       pdWrStb,
  output logic [7:0] pdWrData,
  input  logic       pdWrAck,
  input  logic       pdRdValid,
  input  logic [7:0] pdRdData,
  output logic       tgtReset
);
  logic ckFall;
  logic ckRise;
  logic lineBit;
  ctlStrobe_t strb;

  dbgt_pin_cond #(.LOW_RESET_CLKS(LOW_RESET_CLKS), .SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rstN(rstN), .ckPin(ckPin), .lineIn(lineIn),
    .ckFall(ckFall), .ckRise(ckRise), .lineBit(lineBit), .resetPulse(tgtReset)
  );

  dbgt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ckFall(ckFall), .ckRise(ckRise), .lineBit(lineBit),
    .driveBitNow(lineOut), .resetPulse(tgtReset), .strb(strb), .dataOe(lineOe)
  );

  dbgt_dpath #(.DEV_ID(DEV_ID), .REV_ID(REV_ID), .PROG_ADDR(PROG_ADDR)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .lineBit(lineBit),
    .engBusy(engBusy), .engError(engError), .pdWrAck(pdWrAck),
    .pdRdValid(pdRdValid), .pdRdData(pdRdData),
    .lineOut(lineOut), .pdWrStb(pdWrStb), .pdWrData(pdWrData)
  );
endmodule

// File: tb/dbg_target_bench.sv
module dbg_target_bench;
  localparam logic [7:0] DEV  = 8'hC3;
  localparam logic [7:0] REV  = 8'h05;
  localparam logic [7:0] PROG = 8'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ckPin = 1'b1;
  logic mDrive = 1'b1;
  logic lineIn, lineOut, lineOe;
  logic engBusy = 1'b0, engError = 1'b0;
  logic pdWrStb, pdWrAck = 1'b0, pdRdValid = 1'b0, tgtReset;
  logic [7:0] pdWrData, pdRdData = 8'h00;

  int nChecks = 0, nFail = 0, wrCount = 0, rstCount = 0, oeBad = 0, oeMiss = 0;
  logic [7:0] lastWr = 8'h00;

  always #10 clk = ~clk;
  assign lineIn = lineOe ? lineOut : mDrive;

  dbg_target #(.DEV_ID(DEV), .REV_ID(REV), .PROG_ADDR(PROG), .LOW_RESET_CLKS(16)) u_dbg_target (
    .clk(clk), .rstN(rstN), .ckPin(ckPin), .lineIn(lineIn), .lineOut(lineOut), .lineOe(lineOe),
    .engBusy(engBusy), .engError(engError), .pdWrStb(pdWrStb), .pdWrData(pdWrData),
    .pdWrAck(pdWrAck), .pdRdValid(pdRdValid), .pdRdData(pdRdData), .tgtReset(tgtReset)
  );

  always @(negedge clk) begin
    if (pdWrStb) begin wrCount++; lastWr = pdWrData; end
    if (tgtReset) rstCount++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic b, output logic got, output logic oeAt);
    mDrive = b;
    @(negedge clk);
    ckPin = 1'b0;
    repeat (5) @(negedge clk);
    got = lineIn; oeAt = lineOe;
    ckPin = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic mStrobe(input logic b);
    logic g, o;
    strobe(b, g, o);
    if (o) oeBad++;
  endtask

  task automatic tStrobe(output logic got);
    logic o;
    strobe(1'b1, got, o);
    if (!o) oeMiss++;
  endtask

  task automatic stopStrobe();
    logic g, o;
    strobe(1'b1, g, o);
    chk("R8 line released after stop", {31'd0, lineOe}, 32'd0);
  endtask

  task automatic head(input logic [1:0] ins);
    mStrobe(1'b1);
    mStrobe(ins[0]); mStrobe(ins[1]);
  endtask

  task automatic addrWrite(input logic [7:0] a);
    head(2'd3);
    for (int i = 0; i < 8; i++) mStrobe(a[i]);
    stopStrobe();
  endtask

  task automatic addrRead(output logic [7:0] s);
    logic g;
    head(2'd2);
    for (int i = 0; i < 8; i++) begin tStrobe(g); s[i] = g; end
    stopStrobe();
  endtask

  task automatic pulseAck();
    @(negedge clk) pdWrAck = 1'b1;
    @(negedge clk) pdWrAck = 1'b0;
  endtask

  task automatic pulseRd(input logic [7:0] v);
    @(negedge clk) begin pdRdValid = 1'b1; pdRdData = v; end
    @(negedge clk) pdRdValid = 1'b0;
  endtask

  task automatic dataWrite(input logic [1:0] len, input logic [7:0] last, input int ackAfter,
                           input int maxPolls, output int polls, output bit done);
    logic g;
    logic [7:0] b;
    head(2'd1);
    mStrobe(len[0]); mStrobe(len[1]);
    for (int k = 0; k <= int'(len); k++) begin
      b = (k == int'(len)) ? last : ~last;
      for (int i = 0; i < 8; i++) mStrobe(b[i]);
    end
    polls = 0; done = 1'b0;
    while (!done && polls < maxPolls) begin
      if (polls == ackAfter) pulseAck();
      tStrobe(g);
      if (g) done = 1'b1; else polls++;
    end
    if (done) stopStrobe();
  endtask

  task automatic dataRead(input logic [1:0] len, input int supplyAfter, input logic [7:0] v,
                          output logic [31:0] bytes, output int polls);
    logic g;
    bit done;
    head(2'd0);
    mStrobe(len[0]); mStrobe(len[1]);
    polls = 0; done = 1'b0;
    while (!done && polls < 20) begin
      if (polls == supplyAfter) pulseRd(v);
      tStrobe(g);
      if (g) done = 1'b1; else polls++;
    end
    bytes = '0;
    for (int i = 0; i < 8 * (int'(len) + 1); i++) begin tStrobe(g); bytes[i] = g; end
    stopStrobe();
  endtask

  task automatic pinReset();
    mDrive = 1'b1;
    ckPin = 1'b0;
    repeat (30) @(negedge clk);
    ckPin = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [7:0] s;
    logic [31:0] rd;
    int polls, w0;
    bit done;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 reset lineOe", {31'd0, lineOe}, 32'd0);
    chk("R4 reset no write strobe", wrCount, 0);

    // R1 / R2: identifiers
    dataRead(2'd0, -1, 8'h00, rd, polls);
    chk("R1 first read is device id", rd, {24'd0, DEV});
    chk("R6 id read wait answers 1 at once", polls, 0);
    addrWrite(8'h01);
    dataRead(2'd0, -1, 8'h00, rd, polls);
    chk("R2 revision id", rd, {24'd0, REV});
    addrWrite(8'h77);
    dataRead(2'd0, -1, 8'h00, rd, polls);
    chk("R2 unmapped address reads zero", rd, 0);

    // R2: writes to read-only identifiers ignored
    for (int a = 0; a < 2; a++) begin
      addrWrite(a[7:0]);
      dataWrite(2'd0, 8'h3C, -1, 20, polls, done);
      chk("R6 id write wait answers 1 at once", polls, 0);
      dataRead(2'd0, -1, 8'h00, rd, polls);
      chk("R2 id unchanged after write", rd, {24'd0, (a == 0) ? DEV : REV});
    end
    chk("R2 id writes raise no strobe", wrCount, 0);

    // R3: status flag sweep
    for (int f = 0; f < 4; f++) begin
      engBusy = f[1]; engError = f[0];
      addrRead(s);
      chk("R3 status byte engine flags", s, {24'd0, f[1], f[0], 6'b000000});
    end
    engBusy = 1'b0; engError = 1'b0;

    // R4 R5 R6 R7: full byte sweep through programming register
    addrWrite(PROG);
    for (int v = 0; v < 256; v++) begin
      w0 = wrCount;
      dataWrite(2'd0, v[7:0], v % 3, 20, polls, done);
      chk("R6 write wait zeros until ack", polls, v % 3);
      chk("R4 one write strobe", wrCount - w0, 1);
      chk("R4 written byte", lastWr, v);
      dataRead(2'd0, v % 2, v[7:0] ^ 8'h5A, rd, polls);
      chk("R5 read result byte", rd, {24'd0, v[7:0] ^ 8'h5A});
      chk("R6 read wait zeros until ready", polls, v % 2);
      if (v % 32 == 0) begin
        addrRead(s);
        chk("R5 output-ready cleared by read", s, 0);
      end
    end

    // R7: multi-byte transfers
    addrWrite(8'h00);
    dataRead(2'd3, -1, 8'h00, rd, polls);
    chk("R7 four-byte read repeats register", rd, {DEV, DEV, DEV, DEV});
    addrWrite(PROG);
    w0 = wrCount;
    dataWrite(2'd2, 8'h9C, 0, 20, polls, done);
    chk("R7 three-byte write single strobe", wrCount - w0, 1);
    chk("R7 three-byte write commits last byte", lastWr, 8'h9C);
    dataRead(2'd1, 0, 8'h77, rd, polls);
    chk("R7 two-byte read of result", rd, 32'h7777);

    // R9 / R3: stalled write aborted by pin reset
    w0 = rstCount;
    dataWrite(2'd0, 8'hE1, -1, 3, polls, done);
    chk("R6 wait holds 0 while input busy", {31'd0, done}, 0);
    pinReset();
    chk("R9 one reset pulse", rstCount - w0, 1);
    chk("R9 line released by pin reset", {31'd0, lineOe}, 0);
    addrRead(s);
    chk("R3 input-busy visible in status", s, 32'h02);
    pulseAck();
    pulseRd(8'h11);
    addrRead(s);
    chk("R3 output-ready visible, input-busy cleared", s, 32'h01);
    dataRead(2'd0, -1, 8'h00, rd, polls);
    chk("R1 pin reset returns address to device id", rd, {24'd0, DEV});
    chk("R9 short strobes never reset", rstCount - w0, 1);
    chk("R8 host fields never driven", oeBad, 0);
    chk("R8 target fields always driven", oeMiss, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule